// File: doc/BRIEF.md
# Per-Pixel Colour Source Merge

This block turns a stream of aligned pixel triples into a stream of 24-bit RGB values. Each incoming pixel carries an 8-bit palette index, a 32-bit direct-colour word and a 32-bit control word. The top byte of the control word picks the source of the pixel's colour: the direct word's low 24 bits, or the palette entry the index points to. The block sends the palette read on its own port and keeps the direct path and the source choice aligned with the one-cycle palette latency. Pixels leave in the order they arrived.

It sits between the frame-memory fetch logic, which supplies up to 1024 pixels per scanline with start and end markers, and the display output logic, which can stall. A build parameter removes the direct and control planes for an index-only frame store. A run-time input forces every pixel through the palette when the wider planes are not in use.

The palette port is a synchronous read with an enable. Data for a request appears in the cycle after the request and stays on the port until the next request.

Top module: `pix_colour_merge`

## Requirements
- R1: After reset, out_valid and pal_rd_en are 0 and in_ready is 1.
- R2: A pixel whose control word has bits 31:24 equal to 0x03, with cfg_index_only at 0, leaves with out_rgb[23:16] = direct bits 23:16 (red), out_rgb[15:8] = direct bits 15:8 (green) and out_rgb[7:0] = direct bits 7:0 (blue). Direct bits 31:24 and control bits 23:0 have no effect.
- R3: A pixel whose control top byte is any value other than 0x03 leaves with out_rgb equal to the 24-bit palette data returned for its index.
- R4: With cfg_index_only at 1, every pixel takes its colour from the palette, whatever its control word holds.
- R5: pal_rd_en is 1 exactly in the cycles where a pixel is accepted (in_valid and in_ready both 1), and pal_rd_addr then equals in_index.
- R6: Every accepted pixel produces exactly one output pixel, in acceptance order, with its start-of-line and end-of-line flags unchanged.
- R7: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_rgb, out_sol and out_eol hold their values on the next cycle.
- R8: With out_ready held at 1, a pixel is accepted every cycle. A pixel accepted in cycle t is presented on the output in cycle t+2 and not in cycle t+1.
- R9: With out_ready held at 0, the block accepts exactly two pixels and then holds in_ready at 0. No palette request is issued while in_ready is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_index_only | input | 1 | 1: every pixel uses the palette |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high together with in_valid |
| in_index | input | 8 | Palette index of the pixel |
| in_direct | input | 32 | Direct-colour word, RGB in bits 23:0 |
| in_ctrl | input | 32 | Control word, source code in bits 31:24 |
| in_sol | input | 1 | Pixel starts a scanline |
| in_eol | input | 1 | Pixel ends a scanline |
| pal_rd_en | output | 1 | Palette read request |
| pal_rd_addr | output | 8 | Palette read index |
| pal_rd_data | input | 24 | Palette colour, valid the cycle after a request and held until the next |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts the output pixel |
| out_rgb | output | 24 | Colour: red 23:16, green 15:8, blue 7:0 |
| out_sol | output | 1 | Output pixel starts a scanline |
| out_eol | output | 1 | Output pixel ends a scanline |

## Verification
The bench builds the block with its default parameters: 8-bit index, 8-bit channels, 32-bit plane words, source code 0x03 and the direct plane present. This build makes both colour sources selectable per pixel and lets the run-time index-only input be toggled, so the corner cases can be reached in one build. These include a 0x03 code sitting in the wrong byte of the control word and a non-zero top byte in the direct word. A scoreboard computes each pixel's colour from a palette model inside the bench. It runs under a steady, a random and a blocked output-ready pattern, so the bench also checks alignment, order and flag passing while the palette data must be held through a stall.

// File: rtl/pcm_pkg.sv
package pcm_pkg;

    // Which plane supplies the colour of a pixel.
    typedef enum logic {
        SRC_PALETTE = 1'b0,
        SRC_DIRECT  = 1'b1
    } src_sel_e;

    // Default geometry of one pixel triple.
    localparam int unsigned DEF_IDX_W  = 8;
    localparam int unsigned DEF_CHAN_W = 8;
    localparam int unsigned DEF_WORD_W = 32;
    localparam int unsigned DEF_CODE_W = 8;

endpackage

// File: rtl/pcm_mode_decode.sv
// Decodes the per-pixel colour source from the control word.
module pcm_mode_decode #(
    parameter int unsigned WORD_W           = pcm_pkg::DEF_WORD_W,
    parameter int unsigned CODE_W           = pcm_pkg::DEF_CODE_W,
    parameter logic [CODE_W-1:0] DIRECT_CODE = 8'h03,
    parameter bit          HAS_DIRECT_PLANE = 1'b1
) (
    input  logic [WORD_W-1:0] ctrl_word,
    input  logic              index_only,
    output pcm_pkg::src_sel_e sel
);
    import pcm_pkg::*;

    localparam int unsigned CODE_LSB = WORD_W - CODE_W;

    generate
        if (HAS_DIRECT_PLANE) begin : g_dual
            logic [CODE_W-1:0] code;
            logic              unused_low;

            assign code       = ctrl_word[WORD_W-1:CODE_LSB];
            assign unused_low = ^ctrl_word[CODE_LSB-1:0];

            always_comb begin
                sel = SRC_PALETTE;
                if (!index_only && (code == DIRECT_CODE)) begin
                    sel = SRC_DIRECT;
                end
            end
        end else begin : g_index_only
            // Build without direct plane: control plane is absent.
            logic unused_cfg;
            assign unused_cfg = ^{ctrl_word, index_only};
            assign sel        = SRC_PALETTE;
        end
    endgenerate

endmodule

// File: rtl/pcm_req_stage.sv
// First stage: accepts a pixel, issues the palette read, holds the
// direct colour and source choice while the palette answers.
module pcm_req_stage #(
    parameter int unsigned IDX_W = pcm_pkg::DEF_IDX_W,
    parameter int unsigned RGB_W = 3 * pcm_pkg::DEF_CHAN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [IDX_W-1:0]  in_index,
    input  logic [RGB_W-1:0]  in_rgb,
    input  pcm_pkg::src_sel_e in_sel,
    input  logic              in_sol,
    input  logic              in_eol,
    output logic              pal_rd_en,
    output logic [IDX_W-1:0]  pal_rd_addr,
    output logic              hold_valid,
    output pcm_pkg::src_sel_e hold_sel,
    output logic [RGB_W-1:0]  hold_rgb,
    output logic              hold_sol,
    output logic              hold_eol,
    input  logic              hold_take
);
    import pcm_pkg::*;

    typedef struct packed {
        logic             vld;
        src_sel_e         sel;
        logic [RGB_W-1:0] rgb;
        logic             sol;
        logic             eol;
    } hold_t;

    hold_t hold_d, hold_q;
    logic  accept;

    always_comb begin
        hold_d   = hold_q;
        in_ready = !hold_q.vld || hold_take;
        accept   = in_valid && in_ready;
        if (hold_take) begin
            hold_d.vld = 1'b0;
        end
        if (accept) begin
            hold_d.vld = 1'b1;
            hold_d.sel = in_sel;
            hold_d.rgb = in_rgb;
            hold_d.sol = in_sol;
            hold_d.eol = in_eol;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    // Read is issued only on acceptance, so the palette data stays put
    // until this stage hands its pixel on.
    assign pal_rd_en   = accept;
    assign pal_rd_addr = in_index;

    assign hold_valid = hold_q.vld;
    assign hold_sel   = hold_q.sel;
    assign hold_rgb   = hold_q.rgb;
    assign hold_sol   = hold_q.sol;
    assign hold_eol   = hold_q.eol;

endmodule

// File: rtl/pcm_out_stage.sv
// Second stage: picks the colour source and holds the output pixel
// under backpressure.
module pcm_out_stage #(
    parameter int unsigned RGB_W = 3 * pcm_pkg::DEF_CHAN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_valid,
    input  pcm_pkg::src_sel_e hold_sel,
    input  logic [RGB_W-1:0]  hold_rgb,
    input  logic              hold_sol,
    input  logic              hold_eol,
    output logic              hold_take,
    input  logic [RGB_W-1:0]  pal_rd_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [RGB_W-1:0]  out_rgb,
    output logic              out_sol,
    output logic              out_eol
);
    import pcm_pkg::*;

    typedef struct packed {
        logic             vld;
        logic [RGB_W-1:0] rgb;
        logic             sol;
        logic             eol;
    } pix_t;

    pix_t pix_d, pix_q;
    logic [RGB_W-1:0] colour;

    always_comb begin
        colour    = (hold_sel == SRC_DIRECT) ? hold_rgb : pal_rd_data;
        hold_take = hold_valid && (!pix_q.vld || out_ready);
        pix_d     = pix_q;
        if (pix_q.vld && out_ready) begin
            pix_d.vld = 1'b0;
        end
        if (hold_take) begin
            pix_d.vld = 1'b1;
            pix_d.rgb = colour;
            pix_d.sol = hold_sol;
            pix_d.eol = hold_eol;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_q <= '0;
        end else begin
            pix_q <= pix_d;
        end
    end

    assign out_valid = pix_q.vld;
    assign out_rgb   = pix_q.rgb;
    assign out_sol   = pix_q.sol;
    assign out_eol   = pix_q.eol;

endmodule

// File: rtl/pix_colour_merge.sv
module pix_colour_merge #(
    parameter int unsigned IDX_W            = pcm_pkg::DEF_IDX_W,
    parameter int unsigned CHAN_W           = pcm_pkg::DEF_CHAN_W,
    parameter int unsigned WORD_W           = pcm_pkg::DEF_WORD_W,
    parameter int unsigned CODE_W           = pcm_pkg::DEF_CODE_W,
    parameter logic [CODE_W-1:0] DIRECT_CODE = 8'h03,
    parameter bit          HAS_DIRECT_PLANE = 1'b1,
    localparam int unsigned RGB_W           = 3 * CHAN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_index_only,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [IDX_W-1:0]  in_index,
    input  logic [WORD_W-1:0] in_direct,
    input  logic [WORD_W-1:0] in_ctrl,
    input  logic              in_sol,
    input  logic              in_eol,
    output logic              pal_rd_en,
    output logic [IDX_W-1:0]  pal_rd_addr,
    input  logic [RGB_W-1:0]  pal_rd_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [RGB_W-1:0]  out_rgb,
    output logic              out_sol,
    output logic              out_eol
);
    import pcm_pkg::*;

    src_sel_e         in_sel;
    logic             hold_valid;
    src_sel_e         hold_sel;
    logic [RGB_W-1:0] hold_rgb;
    logic             hold_sol;
    logic             hold_eol;
    logic             hold_take;
    logic             unused_top;

    // Top byte of the direct word carries no colour.
    assign unused_top = ^in_direct[WORD_W-1:RGB_W];

    pcm_mode_decode #(
        .WORD_W          (WORD_W),
        .CODE_W          (CODE_W),
        .DIRECT_CODE     (DIRECT_CODE),
        .HAS_DIRECT_PLANE(HAS_DIRECT_PLANE)
    ) u_decode (
        .ctrl_word (in_ctrl),
        .index_only(cfg_index_only),
        .sel       (in_sel)
    );

    pcm_req_stage #(
        .IDX_W(IDX_W),
        .RGB_W(RGB_W)
    ) u_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_index   (in_index),
        .in_rgb     (in_direct[RGB_W-1:0]),
        .in_sel     (in_sel),
        .in_sol     (in_sol),
        .in_eol     (in_eol),
        .pal_rd_en  (pal_rd_en),
        .pal_rd_addr(pal_rd_addr),
        .hold_valid (hold_valid),
        .hold_sel   (hold_sel),
        .hold_rgb   (hold_rgb),
        .hold_sol   (hold_sol),
        .hold_eol   (hold_eol),
        .hold_take  (hold_take)
    );

    pcm_out_stage #(
        .RGB_W(RGB_W)
    ) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold_valid (hold_valid),
        .hold_sel   (hold_sel),
        .hold_rgb   (hold_rgb),
        .hold_sol   (hold_sol),
        .hold_eol   (hold_eol),
        .hold_take  (hold_take),
        .pal_rd_data(pal_rd_data),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_rgb    (out_rgb),
        .out_sol    (out_sol),
        .out_eol    (out_eol)
    );

endmodule

// File: rtl/pcm_checker.sv
module pcm_checker #(
    parameter int unsigned RGB_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             pal_rd_en,
    input logic             out_valid,
    input logic             out_ready,
    input logic [RGB_W-1:0] out_rgb,
    input logic             out_sol,
    input logic             out_eol
);
    // Pixels inside the block: accepted minus delivered.
    logic [2:0] occ_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q <= '0;
        end else begin
            occ_q <= occ_q + {2'b0, in_valid && in_ready} - {2'b0, out_valid && out_ready};
        end
    end

    // R1: the output is empty in the first cycle after reset
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !out_valid);

    // R5: a palette read goes out only with an accepted pixel
    a_r5_req_only_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        pal_rd_en |-> (in_valid && in_ready));

    // R5: every accepted pixel issues a palette read
    a_r5_accept_has_req: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |-> pal_rd_en);

    // R6: never more than two pixels held, never a pixel from nowhere
    a_r6_bounded_fill: assert property (@(posedge clk) disable iff (!rst_n)
        occ_q <= 3'd2);

    a_r6_no_phantom: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (occ_q != 3'd0));

    // R7: a stalled output holds
    a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_rgb) && $stable(out_sol) && $stable(out_eol)));

    // R9: input blocks only when the output is stalled
    a_r9_block_cause: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> (out_valid && !out_ready));

endmodule

bind pix_colour_merge pcm_checker #(
    .RGB_W(RGB_W)
) u_pcm_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .pal_rd_en(pal_rd_en),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_rgb  (out_rgb),
    .out_sol  (out_sol),
    .out_eol  (out_eol)
);

// File: tb/pix_colour_merge_tb_top.sv
module pix_colour_merge_tb_top;

    typedef struct {
        logic [23:0] rgb;
        logic        sol;
        logic        eol;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_index_only = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_index = '0;
    logic [31:0] in_direct = '0;
    logic [31:0] in_ctrl = '0;
    logic        in_sol = 1'b0;
    logic        in_eol = 1'b0;
    logic        pal_rd_en;
    logic [7:0]  pal_rd_addr;
    logic [23:0] pal_rd_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [23:0] out_rgb;
    logic        out_sol;
    logic        out_eol;

    int   errors = 0;
    int   checks = 0;
    int   rdy_mode = 0;
    int   tries = 0;
    bit   finished = 1'b0;
    exp_t sb[$];

    always #10 clk = ~clk;

    pix_colour_merge dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_index_only(cfg_index_only),
        .in_valid      (in_valid),
        .in_ready      (in_ready),
        .in_index      (in_index),
        .in_direct     (in_direct),
        .in_ctrl       (in_ctrl),
        .in_sol        (in_sol),
        .in_eol        (in_eol),
        .pal_rd_en     (pal_rd_en),
        .pal_rd_addr   (pal_rd_addr),
        .pal_rd_data   (pal_rd_data),
        .out_valid     (out_valid),
        .out_ready     (out_ready),
        .out_rgb       (out_rgb),
        .out_sol       (out_sol),
        .out_eol       (out_eol)
    );

    function automatic logic [23:0] pal_of(input logic [7:0] i);
        logic [7:0] g;
        g = i * 8'd3 + 8'd17;
        return {i ^ 8'hA5, g, ~i};
    endfunction

    // Palette model: synchronous read, output held without a request.
    always @(posedge clk) begin
        if (pal_rd_en) pal_rd_data <= pal_of(pal_rd_addr);
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Output ready pattern: 0 steady high, 1 random, 2 held low.
    initial begin
        forever begin
            @(negedge clk);
            case (rdy_mode)
                0: out_ready = 1'b1;
                1: out_ready = ($urandom_range(0, 3) != 0);
                default: out_ready = 1'b0;
            endcase
        end
    end

    // Driver: presents one pixel, waits for acceptance, queues the expected colour.
    task automatic send(input logic [7:0] idx, input logic [31:0] dir, input logic [31:0] ctl,
                        input logic sol, input logic eol, input string tag);
        exp_t e;
        @(negedge clk);
        in_valid  = 1'b1;
        in_index  = idx;
        in_direct = dir;
        in_ctrl   = ctl;
        in_sol    = sol;
        in_eol    = eol;
        tries     = 0;
        forever begin
            #5;
            tries++;
            if (in_ready) break;
            @(negedge clk);
        end
        check("R5 request on accept", {7'd0, pal_rd_en, 8'd0, pal_rd_addr}, {7'd0, 1'b1, 8'd0, idx});
        e.rgb = (!cfg_index_only && ctl[31:24] == 8'h03) ? dir[23:0] : pal_of(idx);
        e.sol = sol;
        e.eol = eol;
        e.tag = tag;
        sb.push_back(e);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    // Monitor: compares handshaken outputs with the queue and checks stall hold.
    initial begin
        logic        prev_stall;
        logic [25:0] prev_val;
        exp_t        e;
        prev_stall = 1'b0;
        prev_val   = '0;
        forever begin
            @(negedge clk);
            #5;
            if (rst_n) begin
                if (prev_stall) begin
                    check("R7 stall hold", {5'd0, out_valid, out_sol, out_eol, out_rgb},
                          {5'd0, 1'b1, prev_val});
                end
                if (out_valid && out_ready) begin
                    if (sb.size() == 0) begin
                        checks++;
                        errors++;
                        $display("FAIL R6 extra output actual=%h expected=none", out_rgb);
                    end else begin
                        e = sb.pop_front();
                        check({e.tag, " colour"}, {8'd0, out_rgb}, {8'd0, e.rgb});
                        check("R6 line flags", {30'd0, out_sol, out_eol}, {30'd0, e.sol, e.eol});
                    end
                end
                prev_stall = out_valid && !out_ready;
                prev_val   = {out_sol, out_eol, out_rgb};
            end
        end
    end

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R6 watchdog actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        #5;
        check("R1 out_valid", {31'd0, out_valid}, 32'd0);
        check("R1 pal_rd_en", {31'd0, pal_rd_en}, 32'd0);
        check("R1 in_ready", {31'd0, in_ready}, 32'd1);
        @(negedge clk);
        rst_n = 1'b1;

        // R8: latency of two cycles
        send(8'h10, 32'hEE12_3456, 32'h0300_0000, 1'b1, 1'b0, "R8 latency R2");
        @(negedge clk);
        #5;
        check("R8 not yet at t+1", {31'd0, out_valid}, 32'd0);
        @(negedge clk);
        #5;
        check("R8 present at t+2", {31'd0, out_valid}, 32'd1);

        // R2 and R3: source patterns
        send(8'h01, 32'hFFAA_BBCC, 32'h03FF_FFFF, 1'b1, 1'b0, "R2 direct ctrl low ones");
        send(8'h02, 32'h0011_2233, 32'h0200_0000, 1'b0, 1'b0, "R3 code 0x02");
        send(8'h03, 32'h0044_5566, 32'h0400_0000, 1'b0, 1'b0, "R3 code 0x04");
        send(8'hFF, 32'h0077_8899, 32'hFF00_0000, 1'b0, 1'b0, "R3 code 0xFF");
        send(8'h80, 32'h5AC3_3CA5, 32'h0000_0003, 1'b0, 1'b0, "R3 code in low byte");
        send(8'h00, 32'h0100_0000, 32'h0300_0000, 1'b0, 1'b0, "R2 direct black");
        send(8'h7F, 32'h0013_5724, 32'h0000_0000, 1'b0, 1'b1, "R3 code 0x00");

        // R8: back-to-back acceptance with steady ready
        for (int i = 0; i < 16; i++) begin
            send(8'(i * 7), {8'h5A, 8'(i), 8'(i + 1), 8'(i + 2)},
                 (i % 2 == 0) ? 32'h0300_0000 : 32'h0100_0000,
                 (i == 0), (i == 15), "R8 stream");
            check("R8 accepted first try", tries, 1);
        end
        repeat (4) @(negedge clk);

        // R9: blocked output fills two stages then stops input
        rdy_mode = 2;
        @(negedge clk);
        send(8'h21, 32'h00AB_CDEF, 32'h0300_0000, 1'b1, 1'b0, "R9 first");
        send(8'h22, 32'h0000_0000, 32'h0500_0000, 1'b0, 1'b0, "R9 second palette held");
        @(negedge clk);
        in_valid  = 1'b1;
        in_index  = 8'h33;
        in_ctrl   = 32'h0200_0000;
        for (int k = 0; k < 3; k++) begin
            #5;
            check("R9 in_ready low", {31'd0, in_ready}, 32'd0);
            check("R9 no request", {31'd0, pal_rd_en}, 32'd0);
            @(negedge clk);
        end
        in_valid = 1'b0;
        rdy_mode = 0;
        send(8'h33, 32'h0000_0000, 32'h0200_0000, 1'b0, 1'b1, "R9 third");
        repeat (4) @(negedge clk);

        // R4: index-only forces palette even for code 0x03
        cfg_index_only = 1'b1;
        send(8'h44, 32'h00DE_AD00, 32'h0300_0000, 1'b1, 1'b0, "R4 index only");
        send(8'h45, 32'h00BE_EF00, 32'h03FF_FFFF, 1'b0, 1'b1, "R4 index only");
        repeat (4) @(negedge clk);
        cfg_index_only = 1'b0;

        // Random traffic with random output stalls
        rdy_mode = 1;
        for (int i = 0; i < 200; i++) begin
            logic [31:0] c;
            c = ($urandom_range(0, 1) != 0) ? {8'h03, 24'($urandom)} : $urandom;
            send(8'($urandom), $urandom, c, (i % 32 == 0), (i % 32 == 31), "R2 R3 R6 random");
        end
        rdy_mode = 0;

        // R6: every pixel came out
        for (int w = 0; w < 50 && sb.size() != 0; w++) @(negedge clk);
        repeat (3) @(negedge clk);
        check("R6 queue drained", sb.size(), 0);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule